// File: doc/BRIEF.md
# Indirect Register Access Host Port

This block places a small host bus in front of a bank of 16-bit internal registers. The host sees only two locations, chosen by the command/data select line. A write to the command location can carry a load-pointer command, which aims an internal register pointer at one register. Later transfers on the data location then write or read that register. Each register is named by a group number (1 to N_GROUPS) and an element number within the group (0 to N_ELEMS-1).

The bus has a byte-wide mode and a word-wide mode. Byte-wide mode is the mode after reset. In it, every register access is two transfers, low byte first, and an internal byte pointer moves between them. Reads are served from a prefetch latch. A load-pointer command fills the latch, and so does every complete register read. A complete register write does not refill it. When auto-increment is enabled, the register pointer moves to the next element after each complete access. After the last element of a group it moves to element 0 of the next group, and after the last group it returns to group 1. The bus-width bit and the auto-increment bit are master mode bits. They come in as level inputs.

The register file sits outside the block. It receives the pointer as its address, a write word with a one-cycle write strobe, and it returns the word at that address.

Top module: `hreg_port`

## Requirements
- R1: After reset the pointer is group 1, element 0 (rf_addr = 5'h01), the byte pointer expects the low byte, the prefetch latch holds zero, rf_we is low and dout_oe is low.
- R2: dout_oe is high exactly while cs_n and rd_n are both low. While cs_n is high, rd_n, wr_n and cd have no effect: there is no register write and the pointer does not change.
- R3: A command write (cd = 1) of a byte with bits [7:5] = 0, group field bits [2:0] in 1..N_GROUPS and element field bits [4:3] below N_ELEMS sets rf_addr to bits [4:0] and resets the byte pointer to the low byte. Any other command byte leaves the pointer unchanged.
- R4: A data-port read returns the prefetch latch. An accepted load-pointer command fills the latch with the contents of the newly selected register.
- R5: In byte mode (mode_bus16 = 0), a data write of the low byte makes no register write. The following data write of the high byte makes one write of {high, low} to the pointed register.
- R6: In word mode (mode_bus16 = 1), each data write stores din[15:0] into the pointed register.
- R7: In byte mode, two successive data reads put the low byte and then the high byte on dout[7:0], with dout[15:8] = 0.
- R8: In word mode, a data read returns the full 16-bit register.
- R9: With mode_autoinc = 1, the pointer advances only after a complete register access (never between the two bytes). It goes through element 0..N_ELEMS-1, then to the next group, and wraps from the last group to group 1. With mode_autoinc = 0 the pointer holds.
- R10: The prefetch latch refills after each complete register read. A register write does not refill it, so a read after a write returns the old latch contents.
- R11: A read of the command location drives zero on dout.
- R12: rf_we is a single-cycle pulse, one per completed register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| cd | input | 1 | 1 selects the command location, 0 the data location |
| din | input | 16 | Write data from the host |
| dout | output | 16 | Read data to the host |
| dout_oe | output | 1 | Tri-state enable for dout |
| mode_bus16 | input | 1 | 1 selects word-wide transfers, 0 selects byte-wide |
| mode_autoinc | input | 1 | 1 enables pointer auto-increment |
| rf_addr | output | 5 | Register pointer, {element, group} |
| rf_wdata | output | 16 | Register write word |
| rf_we | output | 1 | Register write strobe |
| rf_rdata | input | 16 | Contents of the register at rf_addr |

## Verification
The assertions assume that the host never asserts rd_n and wr_n together. They also assume that an access keeps its strobe low for at least one clock and is followed by at least one idle clock before the next access starts. Finally, they assume that the mode inputs change only between accesses. Every bus task in the stimulus asserts one strobe for a single clock and then idles two clocks. Mode changes happen only between tasks. Deselected strobe activity is driven only with cs_n held high.

// File: rtl/hreg_pkg.sv
// Shared types for the indirect register host port.
// Assumes nothing beyond the parameters of the top module.
package hreg_pkg;

    // Strobe events decoded from the host bus, each valid for one clock.
    typedef struct packed {
        logic cmd_wr;        // start of a write to the command location
        logic data_wr;       // start of a write to the data location
        logic data_rd_done;  // end of a read from the data location
    } hreg_evt_t;

endpackage

// File: rtl/hreg_strobe.sv
// Host strobe decoder: turns the chip select, read, write and
// command/data lines into single-cycle events. A write acts on its
// first active clock, and a read acts on its last. Assumes read and
// write are never active together.
module hreg_strobe
    import hreg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cs_n,
    input  logic      rd_n,
    input  logic      wr_n,
    input  logic      cd,
    output logic      rd_act,
    output hreg_evt_t evt
);

    logic wr_act;
    logic rd_q;
    logic wr_q;
    logic rd_cd_q;
    logic wr_start;

    // Strobes count only while the chip is selected.
    assign rd_act = ~cs_n & ~rd_n;
    assign wr_act = ~cs_n & ~wr_n;

    // Remembers the previous strobe state, and the location a read targets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q    <= 1'b0;
            wr_q    <= 1'b0;
            rd_cd_q <= 1'b0;
        end else begin
            rd_q <= rd_act;
            wr_q <= wr_act;
            if (rd_act && !rd_q) begin
                rd_cd_q <= cd;
            end
        end
    end

    // Event decode: write on its leading edge, read on its trailing edge.
    always_comb begin
        wr_start         = wr_act & ~wr_q;
        evt.cmd_wr       = wr_start & cd;
        evt.data_wr      = wr_start & ~cd;
        evt.data_rd_done = rd_q & ~rd_act & ~rd_cd_q;
    end

endmodule

// File: rtl/hreg_pointer.sv
// Register pointer: holds the {element, group} address. Accepts
// load-pointer commands and steps through elements and groups with
// wrap-around. Invalid command bytes are ignored. A load wins over
// a step in the same clock.
module hreg_pointer #(
    parameter int GRP_W    = 3,
    parameter int ELEM_W   = 2,
    parameter int N_GROUPS = 5,
    parameter int N_ELEMS  = 3,
    parameter int CMD_W    = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_wr,
    input  logic [CMD_W-1:0]         cmd_byte,
    input  logic                     step,
    output logic [GRP_W+ELEM_W-1:0]  ptr,
    output logic                     ptr_loaded
);

    localparam int PTR_W = GRP_W + ELEM_W;
    localparam logic [GRP_W-1:0]  GRP_FIRST = GRP_W'(1);
    localparam logic [GRP_W-1:0]  GRP_LAST  = GRP_W'(N_GROUPS);
    localparam logic [ELEM_W-1:0] ELEM_LAST = ELEM_W'(N_ELEMS - 1);

    logic [GRP_W-1:0]  grp_q;
    logic [ELEM_W-1:0] elem_q;
    logic [GRP_W-1:0]  cmd_grp;
    logic [ELEM_W-1:0] cmd_elem;
    logic              cmd_ok;
    logic [GRP_W-1:0]  nxt_grp;
    logic [ELEM_W-1:0] nxt_elem;

    // Splits the command byte into its fields and checks their ranges.
    always_comb begin
        cmd_grp  = cmd_byte[GRP_W-1:0];
        cmd_elem = cmd_byte[PTR_W-1:GRP_W];
        cmd_ok   = (cmd_byte[CMD_W-1:PTR_W] == '0) &&
                   (cmd_grp != '0) && (cmd_grp <= GRP_LAST) &&
                   (cmd_elem <= ELEM_LAST);
    end

    assign ptr_loaded = cmd_wr & cmd_ok;

    // Works out the next element, moving into the next group after the last one.
    always_comb begin
        if (elem_q == ELEM_LAST) begin
            nxt_elem = '0;
            nxt_grp  = (grp_q == GRP_LAST) ? GRP_FIRST : grp_q + GRP_FIRST;
        end else begin
            nxt_elem = elem_q + ELEM_W'(1);
            nxt_grp  = grp_q;
        end
    end

    // Pointer register: a command load first, then an auto-increment step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_q  <= GRP_FIRST;
            elem_q <= '0;
        end else if (ptr_loaded) begin
            grp_q  <= cmd_grp;
            elem_q <= cmd_elem;
        end else if (step) begin
            grp_q  <= nxt_grp;
            elem_q <= nxt_elem;
        end
    end

    assign ptr = {elem_q, grp_q};

endmodule

// File: rtl/hreg_datapath.sv
// Data path: the byte pointer, the low-byte staging register, the
// registered write word and strobe, the read prefetch latch and the
// read multiplexer. Assumes the mode inputs are stable during an access.
module hreg_datapath
    import hreg_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus16,
    input  logic              cd,
    input  logic [DATA_W-1:0] din,
    input  logic [DATA_W-1:0] rf_rdata,
    input  hreg_evt_t         evt,
    input  logic              ptr_loaded,
    output logic              rf_we,
    output logic [DATA_W-1:0] rf_wdata,
    output logic [DATA_W-1:0] dout,
    output logic              read_done
);

    localparam int BYTE_W = DATA_W / 2;

    logic              byte_hi;
    logic              refill_q;
    logic [BYTE_W-1:0] stage_q;
    logic [DATA_W-1:0] pref_q;
    logic              word_complete;

    // A transfer finishes a register access in word mode, or on the high byte.
    assign word_complete = bus16 | byte_hi;
    assign read_done     = evt.data_rd_done & word_complete;

    // Byte pointer: cleared by a pointer load or in word mode, toggles per transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_hi <= 1'b0;
        end else if (ptr_loaded || bus16) begin
            byte_hi <= 1'b0;
        end else if (evt.data_wr || evt.data_rd_done) begin
            byte_hi <= ~byte_hi;
        end
    end

    // Write path: stage the low byte, or issue a one-clock write of the full word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_we    <= 1'b0;
            rf_wdata <= '0;
            stage_q  <= '0;
        end else begin
            rf_we <= 1'b0;
            if (evt.data_wr) begin
                if (word_complete) begin
                    rf_we    <= 1'b1;
                    rf_wdata <= bus16 ? din : {din[BYTE_W-1:0], stage_q};
                end else begin
                    stage_q <= din[BYTE_W-1:0];
                end
            end
        end
    end

    // Prefetch latch: reload one clock after a pointer load or a complete read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            refill_q <= 1'b0;
            pref_q   <= '0;
        end else begin
            refill_q <= ptr_loaded | read_done;
            if (refill_q) begin
                pref_q <= rf_rdata;
            end
        end
    end

    // Read mux: zero for the command location, else the word or the selected byte.
    always_comb begin
        if (cd) begin
            dout = '0;
        end else if (bus16) begin
            dout = pref_q;
        end else begin
            dout = {{BYTE_W{1'b0}},
                    (byte_hi ? pref_q[DATA_W-1:BYTE_W] : pref_q[BYTE_W-1:0])};
        end
    end

endmodule

// File: rtl/hreg_port.sv
// Indirect register host port, top level. A two-location host bus,
// where a command write loads a register pointer and data transfers
// move register contents in byte or word mode. It supports optional
// pointer auto-increment and serves reads from a prefetch latch. Assumes
// rd_n and wr_n are never low together and that there is an idle clock
// between accesses.
module hreg_port
    import hreg_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int GRP_W    = 3,
    parameter int ELEM_W   = 2,
    parameter int N_GROUPS = 5,
    parameter int N_ELEMS  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cs_n,
    input  logic                    rd_n,
    input  logic                    wr_n,
    input  logic                    cd,
    input  logic [DATA_W-1:0]       din,
    output logic [DATA_W-1:0]       dout,
    output logic                    dout_oe,
    input  logic                    mode_bus16,
    input  logic                    mode_autoinc,
    output logic [GRP_W+ELEM_W-1:0] rf_addr,
    output logic [DATA_W-1:0]       rf_wdata,
    output logic                    rf_we,
    input  logic [DATA_W-1:0]       rf_rdata
);

    localparam int BYTE_W = DATA_W / 2;

    hreg_evt_t evt;
    logic      ptr_loaded;
    logic      read_done;
    logic      step;

    hreg_strobe u_strobe (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .rd_n   (rd_n),
        .wr_n   (wr_n),
        .cd     (cd),
        .rd_act (dout_oe),
        .evt    (evt)
    );

    // The pointer steps on the clock that consumes a write, or after a complete read.
    assign step = mode_autoinc & (rf_we | read_done);

    hreg_pointer #(
        .GRP_W    (GRP_W),
        .ELEM_W   (ELEM_W),
        .N_GROUPS (N_GROUPS),
        .N_ELEMS  (N_ELEMS),
        .CMD_W    (BYTE_W)
    ) u_pointer (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_wr     (evt.cmd_wr),
        .cmd_byte   (din[BYTE_W-1:0]),
        .step       (step),
        .ptr        (rf_addr),
        .ptr_loaded (ptr_loaded)
    );

    hreg_datapath #(
        .DATA_W (DATA_W)
    ) u_datapath (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus16      (mode_bus16),
        .cd         (cd),
        .din        (din),
        .rf_rdata   (rf_rdata),
        .evt        (evt),
        .ptr_loaded (ptr_loaded),
        .rf_we      (rf_we),
        .rf_wdata   (rf_wdata),
        .dout       (dout),
        .read_done  (read_done)
    );

endmodule

// File: rtl/hreg_port_chk.sv
// Assertion checker for hreg_port, attached with bind. Assumes the
// host keeps read and write apart, with an idle clock between accesses.
module hreg_port_chk #(
    parameter int DATA_W   = 16,
    parameter int GRP_W    = 3,
    parameter int ELEM_W   = 2,
    parameter int N_GROUPS = 5,
    parameter int N_ELEMS  = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cs_n,
    input logic                    wr_n,
    input logic                    cd,
    input logic [DATA_W-1:0]       dout,
    input logic                    dout_oe,
    input logic [GRP_W+ELEM_W-1:0] rf_addr,
    input logic                    rf_we
);

    localparam int PTR_W = GRP_W + ELEM_W;
    localparam logic [GRP_W-1:0]  GRP_LAST  = GRP_W'(N_GROUPS);
    localparam logic [ELEM_W-1:0] ELEM_LAST = ELEM_W'(N_ELEMS - 1);

    // R2: no drive on the bus while deselected
    assert_quiet_deselect_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !dout_oe);

    // R5: every register write follows a selected data-location write strobe
    assert_write_from_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> $past(!cs_n && !wr_n && !cd));

    // R12: the write strobe lasts one clock
    assert_we_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |=> !rf_we);

    // R9: the pointer never leaves the legal group and element range
    assert_ptr_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_addr[GRP_W-1:0] != '0) && (rf_addr[GRP_W-1:0] <= GRP_LAST) &&
        (rf_addr[PTR_W-1:GRP_W] <= ELEM_LAST));

    // R11: command-location reads return zero
    assert_cmd_read_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_oe && cd) |-> (dout == '0));

endmodule

bind hreg_port hreg_port_chk #(
    .DATA_W   (DATA_W),
    .GRP_W    (GRP_W),
    .ELEM_W   (ELEM_W),
    .N_GROUPS (N_GROUPS),
    .N_ELEMS  (N_ELEMS)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .wr_n    (wr_n),
    .cd      (cd),
    .dout    (dout),
    .dout_oe (dout_oe),
    .rf_addr (rf_addr),
    .rf_we   (rf_we)
);

// File: tb/hreg_port_tb.sv
// Self-checking bench for hreg_port. It contains its own register-file model.
module hreg_port_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        cd = 1'b0;
    logic [15:0] din = '0;
    logic [15:0] dout;
    logic        dout_oe;
    logic        mode_bus16 = 1'b0;
    logic        mode_autoinc = 1'b0;
    logic [4:0]  rf_addr;
    logic [15:0] rf_wdata;
    logic        rf_we;
    logic [15:0] rf_rdata;

    logic [15:0] regm [32];
    int          we_cnt;
    int          n_cmp = 0;
    int          n_bad = 0;
    logic        done = 1'b0;

    always #2 clk = ~clk;

    hreg_port u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_n         (cs_n),
        .rd_n         (rd_n),
        .wr_n         (wr_n),
        .cd           (cd),
        .din          (din),
        .dout         (dout),
        .dout_oe      (dout_oe),
        .mode_bus16   (mode_bus16),
        .mode_autoinc (mode_autoinc),
        .rf_addr      (rf_addr),
        .rf_wdata     (rf_wdata),
        .rf_we        (rf_we),
        .rf_rdata     (rf_rdata)
    );

    // Register-file model: preset contents on reset, stores on the write strobe.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) regm[i] <= 16'hA000 + 16'(i);
            we_cnt <= 0;
        end else if (rf_we) begin
            regm[rf_addr] <= rf_wdata;
            we_cnt        <= we_cnt + 1;
        end
    end
    assign rf_rdata = regm[rf_addr];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic c, input logic [15:0] d);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; cd = c; din = d;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic bus_rd(input logic c, output logic [15:0] d, output logic oe);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; cd = c;
        @(negedge clk);
        d  = dout;
        oe = dout_oe;
        cs_n = 1'b1; rd_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic ldp(input logic [7:0] code);
        bus_wr(1'b1, {8'h00, code});
    endtask

    typedef struct packed {
        logic        m16;
        logic [4:0]  ptr;
        logic [15:0] data;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{1'b0, 5'h02, 16'h1234},
        '{1'b1, 5'h0A, 16'hBEEF},
        '{1'b0, 5'h15, 16'h00FF},
        '{1'b1, 5'h11, 16'h8001},
        '{1'b0, 5'h04, 16'hFF00},
        '{1'b1, 5'h0D, 16'h5A5A}
    };

    // Watchdog: a hung run is counted as a failure and still reports.
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] rv;
        logic        oe;
        int          c0;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 rf_addr", 32'(rf_addr), 32'h01);
        chk("R1 rf_we", 32'(rf_we), 32'h0);
        chk("R1 dout_oe", 32'(dout_oe), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        bus_rd(1'b0, rv, oe);
        chk("R1 prefetch low", 32'(rv), 32'h0);
        bus_rd(1'b0, rv, oe);
        chk("R1 prefetch high", 32'(rv), 32'h0);

        // Vector walk: write in the given mode, reload the pointer, read back.
        foreach (VEC[i]) begin
            mode_bus16 = VEC[i].m16;
            ldp({3'b000, VEC[i].ptr});
            if (VEC[i].m16) begin
                bus_wr(1'b0, VEC[i].data);
                chk("R6 word write", 32'(regm[VEC[i].ptr]), 32'(VEC[i].data));
                ldp({3'b000, VEC[i].ptr});
                bus_rd(1'b0, rv, oe);
                chk("R8 word read", 32'(rv), 32'(VEC[i].data));
            end else begin
                bus_wr(1'b0, {8'h00, VEC[i].data[7:0]});
                bus_wr(1'b0, {8'h00, VEC[i].data[15:8]});
                chk("R5 byte write", 32'(regm[VEC[i].ptr]), 32'(VEC[i].data));
                ldp({3'b000, VEC[i].ptr});
                bus_rd(1'b0, rv, oe);
                chk("R7 low byte", 32'(rv), 32'({8'h00, VEC[i].data[7:0]}));
                chk("R2 oe during read", 32'(oe), 32'h1);
                bus_rd(1'b0, rv, oe);
                chk("R7 high byte", 32'(rv), 32'({8'h00, VEC[i].data[15:8]}));
            end
        end

        // R5 and R12: one write strobe per two-byte access
        mode_bus16 = 1'b0;
        ldp(8'h03);
        c0 = we_cnt;
        bus_wr(1'b0, 16'h0034);
        chk("R5 no write after low byte", 32'(we_cnt), 32'(c0));
        bus_wr(1'b0, 16'h0012);
        chk("R12 single write", 32'(we_cnt), 32'(c0 + 1));
        chk("R5 assembled word", 32'(regm[3]), 32'h1234);

        // R3: invalid command bytes are ignored
        ldp(8'h06);
        chk("R3 group out of range", 32'(rf_addr), 32'h03);
        ldp(8'h20);
        chk("R3 other command", 32'(rf_addr), 32'h03);
        ldp(8'h18);
        chk("R3 element out of range", 32'(rf_addr), 32'h03);
        ldp(8'h0C);
        chk("R3 valid load", 32'(rf_addr), 32'h0C);

        // R3: a pointer load restarts the byte sequence
        ldp(8'h02);
        bus_wr(1'b0, 16'h0077);
        ldp(8'h0C);
        bus_wr(1'b0, 16'h0011);
        bus_wr(1'b0, 16'h0022);
        chk("R3 byte pointer reset", 32'(regm[12]), 32'h2211);
        chk("R3 abandoned access", 32'(regm[2]), 32'h1234);

        // R2: strobes ignored while deselected
        c0 = we_cnt;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b0; cd = 1'b1; din = 16'h0001;
        repeat (2) @(negedge clk);
        wr_n = 1'b1; rd_n = 1'b0; cd = 1'b0;
        @(negedge clk);
        chk("R2 no drive deselected", 32'(dout_oe), 32'h0);
        rd_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R2 no write deselected", 32'(we_cnt), 32'(c0));
        chk("R2 pointer held", 32'(rf_addr), 32'h0C);

        // R11: the command location reads as zero
        bus_rd(1'b1, rv, oe);
        chk("R11 command read", 32'(rv), 32'h0);
        chk("R2 oe on command read", 32'(oe), 32'h1);

        // R10 and R4: a write leaves the prefetch stale, a complete read refreshes it
        mode_bus16 = 1'b1;
        ldp(8'h04);
        bus_wr(1'b0, 16'hC0DE);
        chk("R6 word stored", 32'(regm[4]), 32'hC0DE);
        bus_rd(1'b0, rv, oe);
        chk("R10 stale after write", 32'(rv), 32'hFF00);
        bus_rd(1'b0, rv, oe);
        chk("R10 refreshed after read", 32'(rv), 32'hC0DE);

        // R9: auto-increment over elements and groups, word mode
        mode_autoinc = 1'b1;
        ldp(8'h01);
        bus_rd(1'b0, rv, oe);
        chk("R4 first of group", 32'(rv), 32'(regm[5'h01]));
        bus_rd(1'b0, rv, oe);
        chk("R9 second element", 32'(rv), 32'(regm[5'h09]));
        bus_rd(1'b0, rv, oe);
        chk("R9 third element", 32'(rv), 32'(regm[5'h11]));
        chk("R9 next group", 32'(rf_addr), 32'h02);
        ldp(8'h15);
        bus_rd(1'b0, rv, oe);
        chk("R9 last register", 32'(rv), 32'(regm[5'h15]));
        chk("R9 wrap to group 1", 32'(rf_addr), 32'h01);

        // R9: byte mode steps only after the high byte
        mode_bus16 = 1'b0;
        ldp(8'h13);
        bus_wr(1'b0, 16'h00AD);
        chk("R9 no step mid write", 32'(rf_addr), 32'h13);
        bus_wr(1'b0, 16'h00DE);
        chk("R9 step after write", 32'(rf_addr), 32'h04);
        chk("R5 autoinc write", 32'(regm[5'h13]), 32'hDEAD);
        ldp(8'h13);
        bus_rd(1'b0, rv, oe);
        chk("R7 autoinc low", 32'(rv), 32'h00AD);
        chk("R9 no step mid read", 32'(rf_addr), 32'h13);
        bus_rd(1'b0, rv, oe);
        chk("R7 autoinc high", 32'(rv), 32'h00DE);
        chk("R9 step after read", 32'(rf_addr), 32'h04);
        bus_rd(1'b0, rv, oe);
        chk("R10 fresh after step", 32'(rv), 32'h00DE);

        // R9: pointer holds without auto-increment
        mode_autoinc = 1'b0;
        mode_bus16   = 1'b1;
        ldp(8'h05);
        bus_rd(1'b0, rv, oe);
        chk("R9 hold pointer", 32'(rf_addr), 32'h05);
        chk("R8 read group 5", 32'(rv), 32'(regm[5'h05]));

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule